// File: doc/BRIEF.md
# Counter-Timed Serial ADC Reader

This block reads an 8-bit serial-output analog-to-digital converter with no state machine. One free-running binary counter on the 4 MHz system clock produces every timing signal. One counter bit is the converter clock. The two top counter bits, decoded, make an active-low chip select. At each falling edge of the converter clock, the serial data line enters the low end of a shift register. Once per 256-cycle frame, a decode of the upper counter bits copies the shift register into a held result register.

All logic runs on the system clock. Each falling converter-clock edge becomes a one-cycle enable, raised when the low four counter bits read all ones. A synchronous reset clears the counter and both registers. While reset is held it forces chip select high.

Top module: `svadc_reader`

## Requirements
- R1: While reset is sampled high, the next cycle shows `adc_sclk` = 0, `adc_cs_n` = 1 and `result` = 0. The internal count restarts at 0.
- R2: After each count value c, `adc_sclk` equals bit 3 of c. It is low for 8 cycles and then high for 8, which gives a period of 16 system clocks (250 kHz at 4 MHz). Its first rise comes 8 clocks after reset is released.
- R3: A frame is 256 clocks. `adc_cs_n` is high (deasserted) while the count is in 192..255, for 64 cycles. It is low for the other 192 cycles.
- R4: `adc_dout` is sampled only on the clock edge where the low four count bits pass from 1111 to 0000, which is where `adc_sclk` falls. The new bit enters bit 0 and earlier bits move toward bit 7.
- R5: `result` changes only on the edge where the count passes from 0xAF to 0xB0. It takes the bits sampled at counts 0x2F, 0x3F, …, 0x9F, and the first of these becomes bit 7 (MSB first).
- R6: Between captures `result` holds. Toggling `adc_dout` on cycles that are not sampling edges has no effect on it.
- R7: Bits sampled at counts outside 0x2F..0x9F never appear in the next `result`. These include the bits sampled while chip select is high.
- R8: A reset in mid-frame restarts the frame from count 0. `result` reads 0 until the first capture after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_dout | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Converter clock, system clock / 16 |
| adc_cs_n | output | 1 | Converter chip select, active low |
| result | output | 8 | Last captured 8-bit conversion value |

## Verification
The hardest case to reach is a data line that changes on every cycle except the eight sampling edges inside the capture window. It must still produce exactly the intended byte, and bits at the other eight sampling edges must be discarded. The stimulus tracks the frame position and drives the intended bit only at the sampling cycles from 0x2F to 0x9F. On every other cycle it drives random noise, so a sampling point that is off by one cycle or one slot corrupts the captured value. A reset pulse in mid-frame checks the restart, and the cleared result must hold until the next capture.

// File: rtl/svadc_pkg.sv
package svadc_pkg;
    // Default geometry of the reader.
    localparam int unsigned CNT_W_DEF   = 8;   // frame counter width, 256-cycle frame
    localparam int unsigned CLK_BIT_DEF = 3;   // counter bit driving the converter clock
    localparam int unsigned DATA_W_DEF  = 8;   // converter sample width
    localparam logic [3:0]  CAP_DEF     = 4'b1010; // upper-count slot that commits the sample
endpackage

// File: rtl/svadc_timebase.sv
module svadc_timebase #(
    parameter int unsigned CNT_W   = svadc_pkg::CNT_W_DEF,
    parameter int unsigned CLK_BIT = svadc_pkg::CLK_BIT_DEF,
    parameter logic [CNT_W-CLK_BIT-2:0] CAP_CODE = svadc_pkg::CAP_DEF
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sclk_o,
    output logic             cs_n_o,
    output logic             shift_en_o,
    output logic             cap_en_o
);
    localparam int unsigned HI_W = CNT_W - CLK_BIT - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             cs_n;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b0;
            st_d.cs_n = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.sclk = st_d.cnt[CLK_BIT];
            st_d.cs_n = &st_d.cnt[CNT_W-1:CNT_W-2];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    logic [HI_W-1:0] hi_bits;
    assign hi_bits    = st_q.cnt[CNT_W-1:CLK_BIT+1];
    assign shift_en_o = &st_q.cnt[CLK_BIT:0];
    assign cap_en_o   = shift_en_o && (hi_bits == CAP_CODE);
    assign cnt_o      = st_q.cnt;
    assign sclk_o     = st_q.sclk;
    assign cs_n_o     = st_q.cs_n;
endmodule

// File: rtl/svadc_capture.sv
module svadc_capture #(
    parameter int unsigned DATA_W = svadc_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              cap_en,
    input  logic              sdata,
    output logic [DATA_W-1:0] shreg_o,
    output logic [DATA_W-1:0] result_o
);
    typedef struct packed {
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] held;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.shreg = '0;
            st_d.held  = '0;
        end else begin
            if (cap_en)
                st_d.held = st_q.shreg;   // commit contents before this edge's shift
            if (shift_en)
                st_d.shreg = {st_q.shreg[DATA_W-2:0], sdata};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign shreg_o  = st_q.shreg;
    assign result_o = st_q.held;
endmodule

// File: rtl/svadc_reader.sv
module svadc_reader #(
    parameter int unsigned CNT_W   = svadc_pkg::CNT_W_DEF,
    parameter int unsigned CLK_BIT = svadc_pkg::CLK_BIT_DEF,
    parameter int unsigned DATA_W  = svadc_pkg::DATA_W_DEF,
    parameter logic [CNT_W-CLK_BIT-2:0] CAP_CODE = svadc_pkg::CAP_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adc_dout,
    output logic              adc_sclk,
    output logic              adc_cs_n,
    output logic [DATA_W-1:0] result
);
    logic [CNT_W-1:0]  cnt_w;
    logic              shift_en_w;
    logic              cap_en_w;
    logic [DATA_W-1:0] shreg_w;

    svadc_timebase #(
        .CNT_W   (CNT_W),
        .CLK_BIT (CLK_BIT),
        .CAP_CODE(CAP_CODE)
    ) u_timebase (
        .clk       (clk),
        .rst       (rst),
        .cnt_o     (cnt_w),
        .sclk_o    (adc_sclk),
        .cs_n_o    (adc_cs_n),
        .shift_en_o(shift_en_w),
        .cap_en_o  (cap_en_w)
    );

    svadc_capture #(
        .DATA_W(DATA_W)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .shift_en(shift_en_w),
        .cap_en  (cap_en_w),
        .sdata   (adc_dout),
        .shreg_o (shreg_w),
        .result_o(result)
    );
endmodule

// File: rtl/svadc_reader_chk.sv
module svadc_reader_chk #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned CLK_BIT = 3,
    parameter int unsigned DATA_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              adc_dout,
    input logic              adc_sclk,
    input logic              adc_cs_n,
    input logic [DATA_W-1:0] result,
    input logic [CNT_W-1:0]  cnt,
    input logic              shift_en,
    input logic              cap_en,
    input logic [DATA_W-1:0] shreg
);
    localparam logic [CNT_W-1:0] CS_OFF_PRE = {2'b10, {(CNT_W-2){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (adc_cs_n && !adc_sclk && result == '0 && cnt == '0));

    assert_sclk_falls_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt[CLK_BIT:0] == {(CLK_BIT+1){1'b1}}) |=> !adc_sclk);

    assert_cs_release_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt == CS_OFF_PRE) |=> $rose(adc_cs_n));

    assert_cs_assert_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX) |=> !adc_cs_n);

    assert_shift_in_R4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (shreg[0] == $past(adc_dout)));

    assert_commit_R5: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (result == $past(shreg)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(result));
endmodule

bind svadc_reader svadc_reader_chk #(
    .CNT_W  (CNT_W),
    .CLK_BIT(CLK_BIT),
    .DATA_W (DATA_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .adc_dout(adc_dout),
    .adc_sclk(adc_sclk),
    .adc_cs_n(adc_cs_n),
    .result  (result),
    .cnt     (cnt_w),
    .shift_en(shift_en_w),
    .cap_en  (cap_en_w),
    .shreg   (shreg_w)
);

// File: tb/svadc_reader_tb.sv
`timescale 1ns/1ps
module svadc_reader_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adc_dout = 1'b0;
    logic       adc_sclk;
    logic       adc_cs_n;
    logic [7:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    svadc_reader u_dut (
        .clk     (clk),
        .rst     (rst),
        .adc_dout(adc_dout),
        .adc_sclk(adc_sclk),
        .adc_cs_n(adc_cs_n),
        .result  (result)
    );

    // Behavioural reference: frame position, sampled-bit history, held value.
    int         m_pos = 0;
    bit         m_q[$];
    logic [7:0] m_res = 8'h00;
    logic       m_sclk = 1'b0;
    logic       m_csn  = 1'b1;
    bit         m_live = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0;
            m_q.delete();
            for (int i = 0; i < 8; i++) m_q.push_back(1'b0);
            m_res  = 8'h00;
            m_sclk = 1'b0;
            m_csn  = 1'b1;
        end else begin
            if (m_pos == 8'hAF) begin
                for (int i = 0; i < 8; i++) m_res[7-i] = m_q[i];
            end
            if ((m_pos % 16) == 15) begin
                m_q.push_back(adc_dout);
                if (m_q.size() > 8) void'(m_q.pop_front());
            end
            m_pos  = (m_pos + 1) % 256;
            m_sclk = ((m_pos / 8) % 2) == 1;
            m_csn  = (m_pos >= 192);
        end
        m_live = 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at pos %0d: actual %0h expected %0h", req, what, m_pos, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (m_live) begin
            check("R2", "adc_sclk", adc_sclk, m_sclk);
            check("R3", "adc_cs_n", adc_cs_n, m_csn);
            check("R5 R6", "result", result, m_res);
        end
    end

    // Drive one frame: true bits at the eight sampling edges of the window, noise elsewhere (R4, R6, R7).
    task automatic run_frame(input logic [7:0] pat);
        while (m_pos != 0) @(negedge clk);
        for (int k = 0; k < 256; k++) begin
            int slot;
            slot = m_pos / 16;
            if ((m_pos % 16) == 15 && slot >= 2 && slot <= 9)
                adc_dout = pat[9-slot];
            else
                adc_dout = 1'($urandom);
            @(negedge clk);
        end
        check("R5 R7", "frame result", result, pat);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01};
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "reset sclk", adc_sclk, 0);
        check("R1", "reset cs_n", adc_cs_n, 1);
        check("R1", "reset result", result, 0);
        rst = 1'b0;
        // R2: first rise of the converter clock 8 clocks after release
        repeat (7) @(negedge clk);
        check("R2", "sclk before 8th edge", adc_sclk, 0);
        @(negedge clk);
        check("R2", "sclk at 8th edge", adc_sclk, 1);
        foreach (pats[i]) run_frame(pats[i]);
        for (int i = 0; i < 6; i++) run_frame(8'($urandom));
        // R8: reset in mid-frame
        while (m_pos != 8'h50) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "mid-frame reset cs_n", adc_cs_n, 1);
        check("R8", "mid-frame reset result", result, 0);
        rst = 1'b0;
        repeat (8'hA0) @(negedge clk);
        check("R8", "result before first capture", result, 0);
        run_frame(8'hC3);
        run_frame(8'h3C);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule